// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a small bus-attached controller. A free-running counter advances on every enabled clock and, when it reaches the selected period, asks the system for a reset. Software keeps the system alive by writing a restart key to the enable register, which clears the counter. Anything that looks like runaway code asks for a reset instead: a wrong key, a bit-level access to the enable register, or a second write to the mode register.

The mode register can be written once after reset. It picks the overflow period and, when a strap allows it, stops the timer. A clock-enable input models a halted source clock. While it is low the counter is frozen, and any reset cause is held until the clock runs again. The reset request is a one-cycle registered pulse for an external reset controller.

Top module: `wdt_keyed`

## Requirements
- R1: A non-bit write of 0xAC to the enable address clears the counter to zero, and counting restarts from there. It does not raise a request.
- R2: A write of any other value to the enable address raises a reset request on the cycle after the write.
- R3: Any read or write to the enable address with `bit_access_i` high raises a reset request, including a write of 0xAC.
- R4: Reading the enable address always returns 0x9A.
- R5: Mode bits [2:0] hold n. Counting from a clear, the request rises after exactly 2^(10+n) enabled clocks.
- R6: The first mode write after reset stores bit 4 and bits [2:0], and reads return them in place with all other bits zero. A later mode write raises a request and leaves the stored value unchanged.
- R7: When `strap_stoppable_i` is 1 and mode bit 4 is set, the counter holds and no overflow request is raised. When the strap is 0, bit 4 has no effect.
- R8: While `clk_en_i` is low the counter holds and no request is issued. A request caused during that time is issued on the first cycle after `clk_en_i` returns high.
- R9: Each request lasts exactly one cycle. After reset the request is low, the mode reads 0x00 and the enable register reads 0x9A.
- R10: Reads and writes to any address other than the enable address and the one after it have no effect, and their reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Source clock running (low = halted) |
| strap_stoppable_i | input | 1 | Strap: 1 lets the mode stop bit halt the timer |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| bit_access_i | input | 1 | Marks the access as a single-bit operation |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as `rd_i` |
| wdt_rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
The hardest case is a reset cause that arrives while the source clock is halted. It must stay pending through many cycles and then come out exactly one cycle after the clock resumes. The bench holds `clk_en_i` low, writes a bad key, watches for silence, and then reopens the clock at a known edge. A second scenario halts the clock partway through a count. The overflow then has to land at an edge shifted by exactly the halted span, which shows the counter really held its value.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned STOP_BIT = 4;
  localparam logic [7:0]  KEY_VAL  = 8'hAC;
  localparam logic [7:0]  EN_RD_VAL = 8'h9A;

  typedef struct packed {
    logic             stop;
    logic [SEL_W-1:0] sel;
  } mode_t;
endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h99
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              bit_access_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output mode_t             mode_o,
  output logic              key_clr_o,
  output logic              viol_o
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = EN_ADDR + 1'b1;

  logic  sel_en, sel_mode;
  mode_t mode_q;
  logic  mode_lock_q;

  assign sel_en   = (addr_i == EN_ADDR);
  assign sel_mode = (addr_i == MODE_ADDR);

  assign key_clr_o = wr_i && sel_en && !bit_access_i && (wdata_i == KEY_VAL);

  // illegal: wrong key, bit op on enable reg, repeated mode write
  assign viol_o = (sel_en && (rd_i || wr_i) && bit_access_i)
               || (sel_en && wr_i && (wdata_i != KEY_VAL))
               || (sel_mode && wr_i && mode_lock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      mode_lock_q <= 1'b0;
    end else if (sel_mode && wr_i && !mode_lock_q) begin
      mode_q.stop <= wdata_i[STOP_BIT];
      mode_q.sel  <= wdata_i[SEL_W-1:0];
      mode_lock_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_en) begin
        rdata_o = EN_RD_VAL;
      end else if (sel_mode) begin
        rdata_o[STOP_BIT]  = mode_q.stop;
        rdata_o[SEL_W-1:0] = mode_q.sel;
      end
    end
  end

  assign mode_o = mode_q;

  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_lock_q |=> (mode_lock_q && $stable(mode_q))); // R6
endmodule

// File: rtl/wdt_keyed_counter.sv
module wdt_keyed_counter
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned BASE_EXP = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             stop_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             ovf_o
);
  localparam int unsigned CNT_W = BASE_EXP + (2 ** SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;
  logic             tick;

  assign tick = clk_en_i && !stop_i;
  assign span = (CNT_W+1)'(1) << (BASE_EXP + int'(sel_i));
  assign last = CNT_W'(span - 1'b1);
  assign ovf_o = tick && !clr_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (ovf_o)   cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  AST_KEY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R1
  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_i) |=> $stable(cnt_q)); // R7
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && !clr_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/wdt_keyed_rstgen.sv
module wdt_keyed_rstgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_en_i,
  input  logic evt_i,
  output logic req_o
);
  logic pend_q, req_q, want;

  assign want = evt_i || pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q  <= want && clk_en_i && !req_q;
      pend_q <= want && (!clk_en_i || req_q);
    end
  end

  assign req_o = req_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R9
  AST_NO_REQ_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> !req_q); // R8
  AST_PEND_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && clk_en_i && !req_q) |=> req_q); // R8
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h99,
  parameter int unsigned BASE_EXP = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              strap_stoppable_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              bit_access_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              wdt_rst_req_o
);
  mode_t mode;
  logic  key_clr, viol, ovf, stop;

  wdt_keyed_regs #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .bit_access_i, .wdata_i,
    .rdata_o, .mode_o(mode), .key_clr_o(key_clr), .viol_o(viol)
  );

  assign stop = strap_stoppable_i && mode.stop;

  wdt_keyed_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk_i, .rst_ni, .clk_en_i, .stop_i(stop), .sel_i(mode.sel),
    .clr_i(key_clr), .ovf_o(ovf)
  );

  wdt_keyed_rstgen u_rst (
    .clk_i, .rst_ni, .clk_en_i, .evt_i(viol || ovf), .req_o(wdt_rst_req_o)
  );

  AST_BAD_KEY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == EN_ADDR && wdata_i != KEY_VAL && clk_en_i && !wdt_rst_req_o)
    |=> wdt_rst_req_o); // R2
endmodule

// File: tb/wdt_keyed_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_tb_top;
  localparam logic [7:0] EN = 8'h99;
  localparam logic [7:0] MD = 8'h9A;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, strap = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0, bitf = 1'b0, req;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdt_keyed dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .strap_stoppable_i(strap),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .bit_access_i(bitf), .wdata_i(wdata),
    .rdata_o(rdata), .wdt_rst_req_o(req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 0; rd = 0; bitf = 0; clk_en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns at the negedge after the capturing posedge
  task automatic bus_wr(logic [7:0] a, logic [7:0] d, logic b);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; bitf = b;
    @(negedge clk);
    wr = 1'b0; bitf = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic b, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1; bitf = b;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; bitf = 1'b0;
  endtask

  task automatic expect_ovf(int n, string tag);
    repeat (n - 1) @(negedge clk);
    chk({tag, " before period"}, req, 0);
    @(negedge clk);
    chk({tag, " at period"}, req, 1);
    @(negedge clk);
    chk("R9 pulse width", req, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R9 req after reset", req, 0);
    bus_rd(EN, 0, d); chk("R4 enable readback", d, 8'h9A);
    bus_rd(MD, 0, d); chk("R9 mode after reset", d, 8'h00);
  endtask

  task automatic t_key_restart();
    do_reset();
    bus_wr(EN, 8'hAC, 0);
    chk("R1 key raises no req", req, 0);
    repeat (600) @(negedge clk);
    bus_wr(EN, 8'hAC, 0);
    expect_ovf(1024, "R1/R5 restart n=0");
  endtask

  task automatic t_bad_key();
    do_reset();
    bus_wr(EN, 8'h55, 0); chk("R2 bad key req", req, 1);
    @(negedge clk); chk("R9 bad key pulse end", req, 0);
    bus_wr(EN, 8'h9A, 0); chk("R2 readback value as key", req, 1);
  endtask

  task automatic t_bit_access();
    logic [7:0] d;
    do_reset();
    bus_wr(EN, 8'hAC, 1); chk("R3 bit write of key", req, 1);
    @(negedge clk);
    bus_rd(EN, 1, d); chk("R3 bit read", req, 1);
  endtask

  task automatic t_period();
    logic [7:0] d;
    do_reset();
    bus_wr(MD, 8'h02, 0);
    bus_rd(MD, 0, d); chk("R6 mode readback", d, 8'h02);
    bus_wr(EN, 8'hAC, 0);
    expect_ovf(4096, "R5 n=2");
  endtask

  task automatic t_mode_twice();
    logic [7:0] d;
    do_reset();
    bus_wr(MD, 8'hFF, 0); chk("R6 first mode write no req", req, 0);
    bus_rd(MD, 0, d); chk("R6 field placement", d, 8'h17);
    bus_wr(MD, 8'h03, 0); chk("R6 second mode write req", req, 1);
    bus_rd(MD, 0, d); chk("R6 mode unchanged", d, 8'h17);
  endtask

  task automatic t_stop();
    int seen = 0;
    do_reset();
    strap = 1'b1;
    bus_wr(MD, 8'h10, 0);
    bus_wr(EN, 8'hAC, 0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (req) seen++;
    end
    chk("R7 stopped no overflow", seen, 0);
    do_reset();
    strap = 1'b0;
    bus_wr(MD, 8'h10, 0);
    bus_wr(EN, 8'hAC, 0);
    expect_ovf(1024, "R7 strap off ignores stop");
  endtask

  task automatic t_halt();
    int seen = 0;
    do_reset();
    clk_en = 1'b0;
    bus_wr(EN, 8'h00, 0); chk("R8 no req while halted", req, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req) seen++;
    end
    chk("R8 pending held", seen, 0);
    clk_en = 1'b1;
    @(negedge clk); chk("R8 issued on resume", req, 1);
    @(negedge clk); chk("R9 resume pulse end", req, 0);
    // counter freeze mid-count
    do_reset();
    bus_wr(EN, 8'hAC, 0);
    repeat (500) @(negedge clk);
    clk_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (req) seen++;
    end
    chk("R8 halted no overflow", seen, 0);
    clk_en = 1'b1;
    expect_ovf(524, "R8 count resumes");
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    do_reset();
    bus_wr(8'h9B, 8'h55, 0); chk("R10 foreign write no req", req, 0);
    bus_wr(8'h98, 8'h11, 1); chk("R10 foreign bit write no req", req, 0);
    bus_rd(8'h9B, 0, d); chk("R10 foreign read zero", d, 8'h00);
    bus_wr(MD, 8'h01, 0); chk("R10 mode still writable", req, 0);
    bus_rd(MD, 0, d); chk("R10 mode untouched by foreign", d, 8'h01);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_key_restart();
    t_bad_key();
    t_bit_access();
    t_period();
    t_mode_twice();
    t_stop();
    t_halt();
    t_other_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule